// File: doc/BRIEF.md
# Two-Level Segment/Page Address Translator

This block turns a 24-bit virtual address into a real address by walking two tables held in memory. The top four address bits pick an entry in a segment table whose base address software keeps in a register. That entry says whether the segment exists, where its page table starts and how many page entries the segment has allocated. The next eight address bits then pick an entry in that page table. The entry supplies a 12-bit frame number, and the frame number joined with the 12-bit byte offset forms the real address.

A client presents an address on a valid/ready port. The block issues the segment-entry read and then the page-entry read through a single-outstanding memory read port. It reports the outcome as a one-cycle result: either a real address, or one of three distinct fault codes. Because each segment carries its own page-table length, a segment only needs page entries for the part of it that is in use.

Top module: `seg_page_xlate`

## Requirements
- R1: The virtual address splits, from most to least significant, into a 4-bit segment index [23:20], an 8-bit page index [19:12] and a 12-bit offset [11:0]. The first memory read goes to byte address `table_base + 4*segment`, where `table_base` is the value on `seg_tbl_base` when the request was accepted.
- R2: A segment entry is a 32-bit word: bit 31 = present, bits [30:22] = page count (0..256), bits [21:0] = page table base word address. The second read goes to byte address `{base_word, 2'b00} + 4*page`.
- R3: At most one memory read is outstanding. The page-entry read is issued only after the segment-entry response returns. An unaccepted read keeps `mem_req_valid` high with a stable address.
- R4: A page entry has bit 31 = present and bits [11:0] = frame. On success the result carries `res_fault = 0` and `res_paddr = {frame, offset}`.
- R5: A segment entry with bit 31 clear gives `res_fault = 1`, and no page read is made.
- R6: A page index greater than or equal to the segment's page count gives `res_fault = 2`, and no page read is made. A count of 0 faults every page.
- R7: A page entry with bit 31 clear gives `res_fault = 3`.
- R8: `res_valid` is high for exactly one cycle, in the cycle right after the clock edge that takes in the final memory response. `res_paddr` is 0 whenever `res_fault` is non-zero.
- R9: `req_ready` is high only while no translation is in progress. The virtual address and the table base are captured at acceptance, so later changes on `seg_tbl_base` have no effect on that translation.
- R10: After reset `req_ready` = 1, `res_valid` = 0 and `mem_req_valid` = 0.
- R11: A `mem_rsp_valid` pulse that arrives while no read is outstanding is ignored: it produces no result and disturbs no later translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| seg_tbl_base | input | 24 | Byte address of the segment table, from a software-loaded register |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_vaddr | input | 24 | Virtual address to translate |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 24 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry word |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 2 | 0 ok, 1 segment absent, 2 page beyond segment length, 3 page absent |
| res_paddr | output | 24 | Real address, 0 on a fault |

## Verification
A wrong internal state shows up at the ports within one or two cycles. A stale captured base or index puts a wrong address on `mem_req_addr` on the very next request cycle. A lost outstanding flag either raises a second read before a response or never ends the walk. A mis-decoded entry picks the wrong fault code or real address in the cycle after the final response. The bench keeps its own behavioural model of which read is due and when the result must appear. It compares ready, request address, result strobe, fault code and address on every clock. It also injects stray responses, stalls the grant and rewrites the table base mid-walk.

// File: rtl/sx_pkg.sv
// Package: shared types for the segment/page translator.
// Assumes: fault codes are visible at the top port and must keep these values.
package sx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_SEG_READ  = 3'd1,
        ST_PAGE_READ = 3'd2,
        ST_DONE      = 3'd3,
        ST_FAULT     = 3'd4
    } sx_state_e;

    typedef enum logic [1:0] {
        FLT_NONE     = 2'd0,
        FLT_SEG_ABS  = 2'd1,
        FLT_SEG_LEN  = 2'd2,
        FLT_PAGE_ABS = 2'd3
    } sx_fault_e;

endpackage

// File: rtl/sx_addr_gen.sv
// Module: sx_addr_gen
// Forms the byte address of the segment entry or the page entry.
// Assumes: entries are 4-byte words; the page table base is a word address.
module sx_addr_gen #(
    parameter int SEG_W  = 4,
    parameter int PAGE_W = 8,
    parameter int MA_W   = 24,
    parameter int PTB_W  = MA_W - 2
) (
    input  logic [MA_W-1:0]   tbl_base,
    input  logic [SEG_W-1:0]  seg_idx,
    input  logic [PAGE_W-1:0] page_idx,
    input  logic [PTB_W-1:0]  ptb_word,
    input  logic              sel_page,
    output logic [MA_W-1:0]   entry_addr
);
    localparam int SEG_PAD  = MA_W - SEG_W - 2;
    localparam int PAGE_PAD = MA_W - PAGE_W - 2;

    logic [MA_W-1:0] seg_addr;
    logic [MA_W-1:0] page_addr;

    // Segment entry: table base plus four bytes per segment index.
    always_comb seg_addr = tbl_base + {{SEG_PAD{1'b0}}, seg_idx, 2'b00};

    // Page entry: page table byte base plus four bytes per page index.
    always_comb page_addr = {ptb_word, 2'b00} + {{PAGE_PAD{1'b0}}, page_idx, 2'b00};

    // Pick the address of the phase in progress.
    always_comb entry_addr = sel_page ? page_addr : seg_addr;

endmodule

// File: rtl/sx_entry_dec.sv
// Module: sx_entry_dec
// Decodes the returned table word as a segment entry and as a page entry.
// Assumes: the present bit is the top bit of both formats; segment word holds
// count above base; the page entry frame sits in the low bits.
module sx_entry_dec #(
    parameter int DATA_W  = 32,
    parameter int PAGE_W  = 8,
    parameter int PTB_W   = 22,
    parameter int FRAME_W = 12
) (
    input  logic [DATA_W-1:0]  word,
    input  logic [PAGE_W-1:0]  page_idx,
    output logic               seg_present,
    output logic               seg_len_ok,
    output logic [PTB_W-1:0]   seg_ptb,
    output logic               pg_present,
    output logic [FRAME_W-1:0] pg_frame
);
    localparam int LEN_W = PAGE_W + 1;

    logic [LEN_W-1:0] seg_count;

    // Segment entry fields.
    always_comb begin
        seg_present = word[DATA_W-1];
        seg_count   = word[PTB_W+LEN_W-1:PTB_W];
        seg_ptb     = word[PTB_W-1:0];
    end

    // Page index must fall below the allocated page count.
    always_comb seg_len_ok = {1'b0, page_idx} < seg_count;

    // Page entry fields.
    always_comb begin
        pg_present = word[DATA_W-1];
        pg_frame   = word[FRAME_W-1:0];
    end

endmodule

// File: rtl/sx_ctrl.sv
// Module: sx_ctrl
// Walk sequencer: captures a request, runs the segment read then the page
// read, and presents a one-cycle result or fault.
// Assumes: memory returns exactly one response per accepted read, no earlier
// than the cycle after acceptance.
module sx_ctrl
    import sx_pkg::*;
#(
    parameter int VA_W    = 24,
    parameter int OFF_W   = 12,
    parameter int MA_W    = 24,
    parameter int PTB_W   = 22,
    parameter int FRAME_W = 12,
    parameter int PA_W    = FRAME_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MA_W-1:0]    seg_tbl_base,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    input  logic               mem_rsp_valid,
    input  logic               dec_seg_present,
    input  logic               dec_seg_len_ok,
    input  logic [PTB_W-1:0]   dec_seg_ptb,
    input  logic               dec_pg_present,
    input  logic [FRAME_W-1:0] dec_pg_frame,
    output logic               sel_page,
    output logic [MA_W-1:0]    base_q,
    output logic [VA_W-1:0]    vaddr_q,
    output logic [PTB_W-1:0]   ptb_q,
    output logic               res_valid,
    output logic [1:0]         res_fault,
    output logic [PA_W-1:0]    res_paddr
);
    sx_state_e          state_q;
    sx_fault_e          fault_q;
    logic               issued_q;
    logic [FRAME_W-1:0] frame_q;
    logic               rsp_take;

    // A response counts only while a read is outstanding.
    always_comb rsp_take = issued_q && mem_rsp_valid;

    // Main walk state machine with its captured operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            fault_q  <= FLT_NONE;
            issued_q <= 1'b0;
            base_q   <= '0;
            vaddr_q  <= '0;
            ptb_q    <= '0;
            frame_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vaddr_q  <= req_vaddr;
                        base_q   <= seg_tbl_base;
                        fault_q  <= FLT_NONE;
                        issued_q <= 1'b0;
                        state_q  <= ST_SEG_READ;
                    end
                end
                ST_SEG_READ: begin
                    if (!issued_q && mem_req_ready) begin
                        issued_q <= 1'b1;
                    end else if (rsp_take) begin
                        issued_q <= 1'b0;
                        if (!dec_seg_present) begin
                            fault_q <= FLT_SEG_ABS;
                            state_q <= ST_FAULT;
                        end else if (!dec_seg_len_ok) begin
                            fault_q <= FLT_SEG_LEN;
                            state_q <= ST_FAULT;
                        end else begin
                            ptb_q   <= dec_seg_ptb;
                            state_q <= ST_PAGE_READ;
                        end
                    end
                end
                ST_PAGE_READ: begin
                    if (!issued_q && mem_req_ready) begin
                        issued_q <= 1'b1;
                    end else if (rsp_take) begin
                        issued_q <= 1'b0;
                        if (!dec_pg_present) begin
                            fault_q <= FLT_PAGE_ABS;
                            state_q <= ST_FAULT;
                        end else begin
                            frame_q <= dec_pg_frame;
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_DONE:  state_q <= ST_IDLE;
                ST_FAULT: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Port-side strobes decoded from the walk state.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = ((state_q == ST_SEG_READ) || (state_q == ST_PAGE_READ)) && !issued_q;
        sel_page      = (state_q == ST_PAGE_READ);
        res_valid     = (state_q == ST_DONE) || (state_q == ST_FAULT);
        res_fault     = (state_q == ST_FAULT) ? fault_q : FLT_NONE;
        res_paddr     = (state_q == ST_DONE) ? {frame_q, vaddr_q[OFF_W-1:0]} : '0;
    end

    // R3: the page phase is entered only from a segment phase that took a response.
    p_page_after_seg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAGE_READ && $past(state_q) != ST_PAGE_READ)
        |-> ($past(state_q) == ST_SEG_READ && $past(mem_rsp_valid)));

    // R11: an idle walker without a request stays idle whatever memory returns.
    p_idle_ignores_rsp_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !req_valid) |=> (state_q == ST_IDLE));

    // R8: the result strobe never lasts two cycles.
    p_res_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R8: a faulted result carries no address.
    p_fault_no_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault != 2'd0) |-> (res_paddr == '0));

endmodule

// File: rtl/seg_page_xlate.sv
// Module: seg_page_xlate
// Two-level translator top: segment table, then per-segment page table, then
// frame joined with offset. Connects sequencer, address former and decoder.
// Assumes: a segment entry fits in DATA_W bits (present + count + base word).
module seg_page_xlate #(
    parameter int SEG_W   = 4,
    parameter int PAGE_W  = 8,
    parameter int OFF_W   = 12,
    parameter int MA_W    = 24,
    parameter int DATA_W  = 32,
    parameter int FRAME_W = 12,
    parameter int VA_W    = SEG_W + PAGE_W + OFF_W,
    parameter int PA_W    = FRAME_W + OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MA_W-1:0]   seg_tbl_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_vaddr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              res_valid,
    output logic [1:0]        res_fault,
    output logic [PA_W-1:0]   res_paddr
);
    localparam int PTB_W   = MA_W - 2;
    localparam int PAGE_LO = OFF_W;
    localparam int SEG_LO  = OFF_W + PAGE_W;

    logic               sel_page;
    logic [MA_W-1:0]    base_q;
    logic [VA_W-1:0]    vaddr_q;
    logic [PTB_W-1:0]   ptb_q;
    logic               dec_seg_present;
    logic               dec_seg_len_ok;
    logic [PTB_W-1:0]   dec_seg_ptb;
    logic               dec_pg_present;
    logic [FRAME_W-1:0] dec_pg_frame;
    logic [SEG_W-1:0]   seg_idx;
    logic [PAGE_W-1:0]  page_idx;

    // Index fields of the captured virtual address.
    always_comb begin
        seg_idx  = vaddr_q[SEG_LO +: SEG_W];
        page_idx = vaddr_q[PAGE_LO +: PAGE_W];
    end

    sx_ctrl #(
        .VA_W(VA_W), .OFF_W(OFF_W), .MA_W(MA_W), .PTB_W(PTB_W),
        .FRAME_W(FRAME_W), .PA_W(PA_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .seg_tbl_base(seg_tbl_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_rsp_valid(mem_rsp_valid),
        .dec_seg_present(dec_seg_present), .dec_seg_len_ok(dec_seg_len_ok),
        .dec_seg_ptb(dec_seg_ptb), .dec_pg_present(dec_pg_present),
        .dec_pg_frame(dec_pg_frame),
        .sel_page(sel_page), .base_q(base_q), .vaddr_q(vaddr_q), .ptb_q(ptb_q),
        .res_valid(res_valid), .res_fault(res_fault), .res_paddr(res_paddr)
    );

    sx_addr_gen #(
        .SEG_W(SEG_W), .PAGE_W(PAGE_W), .MA_W(MA_W), .PTB_W(PTB_W)
    ) u_addr (
        .tbl_base(base_q), .seg_idx(seg_idx), .page_idx(page_idx),
        .ptb_word(ptb_q), .sel_page(sel_page), .entry_addr(mem_req_addr)
    );

    sx_entry_dec #(
        .DATA_W(DATA_W), .PAGE_W(PAGE_W), .PTB_W(PTB_W), .FRAME_W(FRAME_W)
    ) u_dec (
        .word(mem_rsp_data), .page_idx(page_idx),
        .seg_present(dec_seg_present), .seg_len_ok(dec_seg_len_ok),
        .seg_ptb(dec_seg_ptb), .pg_present(dec_pg_present), .pg_frame(dec_pg_frame)
    );

    // R3: a read not yet granted stays asserted at the same address.
    p_hold_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R9: acceptance drops ready and starts the segment read next cycle.
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && mem_req_valid));

    // R1: after acceptance the first read targets the captured base region.
    p_first_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (base_q == $past(seg_tbl_base)));

endmodule

// File: tb/tb_seg_page_xlate.sv
module tb_seg_page_xlate;
    localparam int NREQ = 11;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] seg_tbl_base;
    logic        req_valid;
    logic        req_ready;
    logic [23:0] req_vaddr;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [23:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        res_valid;
    logic [1:0]  res_fault;
    logic [23:0] res_paddr;

    always #4 clk = ~clk;   // 125 MHz

    seg_page_xlate dut (
        .clk(clk), .rst_n(rst_n), .seg_tbl_base(seg_tbl_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
        .res_fault(res_fault), .res_paddr(res_paddr)
    );

    int checks = 0;
    int fails  = 0;

    logic [31:0] mem_w [int];
    logic [23:0] t_base [NREQ];
    logic [23:0] t_va   [NREQ];
    logic [1:0]  t_flt  [NREQ];
    logic [23:0] t_pa   [NREQ];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [23:0] a);
        return mem_w.exists(int'(a)) ? mem_w[int'(a)] : 32'h0;
    endfunction

    function automatic logic [31:0] mkseg(input bit v, input int cnt, input logic [23:0] ptb);
        return {v, 9'(cnt), ptb[23:2]};
    endfunction

    function automatic logic [31:0] mkpg(input bit v, input logic [11:0] fr);
        return {v, 19'h0, fr};
    endfunction

    // Behavioural reference state.
    bit          run = 0;
    bit          busy = 0;
    bit          outstanding = 0;
    bit          rsp_due = 0;
    int          phase = 0;
    int          cnt = 0;
    int          idx_sent = 0;
    int          idx_done = 0;
    logic [23:0] exp_addr;
    logic [23:0] cur_va;
    logic [1:0]  exp_flt;
    logic [23:0] exp_pa;
    logic [15:0] lfsr = 16'hACE1;

    always @(negedge clk) begin
        if (run) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            chk(req_ready == !busy, "R9 ready", 32'(req_ready), 32'(!busy));
            if (rsp_due) begin
                chk(res_valid == 1'b1, "R8 strobe", 32'(res_valid), 32'h1);
                chk(res_fault == exp_flt, "R5/R6/R7 fault code", 32'(res_fault), 32'(exp_flt));
                chk(res_paddr == exp_pa, "R4 real address", 32'(res_paddr), 32'(exp_pa));
                chk(res_fault == t_flt[idx_done] && res_paddr == t_pa[idx_done],
                    "R4 table result", {6'h0, res_fault, res_paddr},
                    {6'h0, t_flt[idx_done], t_pa[idx_done]});
                idx_done++;
                busy = 0;
                rsp_due = 0;
            end else begin
                chk(res_valid == 1'b0, "R8 no strobe", 32'(res_valid), 32'h0);
            end
            if (mem_req_valid) begin
                chk(!outstanding && phase != 0, "R3 single read", 32'(outstanding), 32'h0);
                chk(mem_req_addr == exp_addr, (phase == 2) ? "R2 page addr" : "R1 seg addr",
                    32'(mem_req_addr), 32'(exp_addr));
            end
            mem_rsp_valid = 1'b0;
            mem_rsp_data  = 32'h0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    logic [31:0] d;
                    d = rd(exp_addr);
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = d;
                    outstanding   = 0;
                    if (phase == 1) begin
                        if (!d[31]) begin
                            exp_flt = 2'd1; exp_pa = 24'h0; rsp_due = 1; phase = 0;
                        end else if ({1'b0, cur_va[19:12]} >= d[30:22]) begin
                            exp_flt = 2'd2; exp_pa = 24'h0; rsp_due = 1; phase = 0;
                        end else begin
                            exp_addr = {d[21:0], 2'b00} + {14'h0, cur_va[19:12], 2'b00};
                            phase = 2;
                        end
                    end else begin
                        if (!d[31]) begin exp_flt = 2'd3; exp_pa = 24'h0; end
                        else begin exp_flt = 2'd0; exp_pa = {d[11:0], cur_va[11:0]}; end
                        rsp_due = 1;
                        phase = 0;
                    end
                end
            end else if (!outstanding && lfsr[7]) begin
                // R11: stray response with no read in flight.
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = 32'hFFFF_FFFF;
            end
            mem_req_ready = lfsr[0] | lfsr[3];
            if (mem_req_ready && mem_req_valid) begin
                outstanding = 1;
                cnt = 1 + int'(lfsr[5:4]) % 3;
            end
            req_valid = 1'b0;
            if (!busy && req_ready && idx_sent < NREQ) begin
                seg_tbl_base = t_base[idx_sent];
                req_vaddr    = t_va[idx_sent];
                cur_va       = t_va[idx_sent];
                req_valid    = 1'b1;
                busy         = 1;
                phase        = 1;
                exp_addr     = t_base[idx_sent] + {18'h0, t_va[idx_sent][23:20], 2'b00};
                idx_sent++;
            end else begin
                seg_tbl_base = 24'h00F000;   // R9: junk base while walking
                req_vaddr    = 24'hDEAD00;
            end
        end
    end

    initial begin
        int cyc;
        // Tables: base 0x001000 and alternate base 0x002000.
        mem_w[int'(24'h001000 + 0*4)]  = mkseg(1, 256, 24'h010000);
        mem_w[int'(24'h001000 + 1*4)]  = mkseg(0, 256, 24'h010000);
        mem_w[int'(24'h001000 + 2*4)]  = mkseg(1, 4,   24'h020000);
        mem_w[int'(24'h001000 + 3*4)]  = mkseg(1, 0,   24'h010000);
        mem_w[int'(24'h001000 + 15*4)] = mkseg(1, 256, 24'h030000);
        mem_w[int'(24'h002000)]        = mkseg(1, 256, 24'h040000);
        mem_w[int'(24'h010000 + 0*4)]    = mkpg(1, 12'hABC);
        mem_w[int'(24'h010000 + 255*4)]  = mkpg(1, 12'hFFF);
        mem_w[int'(24'h020000 + 3*4)]    = mkpg(1, 12'h123);
        mem_w[int'(24'h020000 + 4*4)]    = mkpg(1, 12'h999);
        mem_w[int'(24'h030000 + 8'h80*4)] = mkpg(1, 12'h5A5);
        mem_w[int'(24'h040000)]          = mkpg(1, 12'h777);
        // Requests with independently worked expected results.
        t_base[0]  = 24'h001000; t_va[0]  = 24'h000123; t_flt[0]  = 0; t_pa[0]  = 24'hABC123; // R4
        t_base[1]  = 24'h001000; t_va[1]  = 24'h0FFFFF; t_flt[1]  = 0; t_pa[1]  = 24'hFFFFFF; // R4 last page
        t_base[2]  = 24'h001000; t_va[2]  = 24'h007010; t_flt[2]  = 3; t_pa[2]  = 24'h0;      // R7
        t_base[3]  = 24'h001000; t_va[3]  = 24'h100000; t_flt[3]  = 1; t_pa[3]  = 24'h0;      // R5
        t_base[4]  = 24'h001000; t_va[4]  = 24'h203456; t_flt[4]  = 0; t_pa[4]  = 24'h123456; // R6 count-1
        t_base[5]  = 24'h001000; t_va[5]  = 24'h204000; t_flt[5]  = 2; t_pa[5]  = 24'h0;      // R6 at count
        t_base[6]  = 24'h001000; t_va[6]  = 24'h300000; t_flt[6]  = 2; t_pa[6]  = 24'h0;      // R6 count 0
        t_base[7]  = 24'h001000; t_va[7]  = 24'hF809AB; t_flt[7]  = 0; t_pa[7]  = 24'h5A59AB; // R1 top seg
        t_base[8]  = 24'h002000; t_va[8]  = 24'h000321; t_flt[8]  = 0; t_pa[8]  = 24'h777321; // R9 base
        t_base[9]  = 24'h001000; t_va[9]  = 24'h500000; t_flt[9]  = 1; t_pa[9]  = 24'h0;      // R5
        t_base[10] = 24'h001000; t_va[10] = 24'h000000; t_flt[10] = 0; t_pa[10] = 24'hABC000; // R11 after strays

        rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; seg_tbl_base = '0;
        mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        repeat (4) @(negedge clk);
        // R10: reset state.
        chk(req_ready == 1'b1, "R10 ready", 32'(req_ready), 32'h1);
        chk(res_valid == 1'b0, "R10 result", 32'(res_valid), 32'h0);
        chk(mem_req_valid == 1'b0, "R10 mem req", 32'(mem_req_valid), 32'h0);
        rst_n = 1'b1;
        run = 1;
        cyc = 0;
        while (idx_done < NREQ && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (idx_done < NREQ) begin
            checks++;
            fails++;
            $display("FAIL watchdog: %0d of %0d translations finished", idx_done, NREQ);
        end
        repeat (3) @(negedge clk);
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule